// File: doc/BRIEF.md
# Timed Radio State Sequencer

This block steers a transceiver between its operating states in response to one-byte commands from a host. The states are idle, PHY ready, receive, transmit, clear-channel assessment, measurement and sleep. Each accepted command starts a settling interval, and the state register moves to the target only when that interval has passed. The interval depends on the current and target states, on the modulation mode, on whether the synthesizer needs a fresh calibration for a new channel, and on a programmable MAC delay extension.

Intervals are counted in half-microsecond ticks, so the fractional settling times are exact. A free-running prescaler on the system clock makes the tick. The block remembers the channel the synthesizer was last calibrated on. Receive or transmit entry on that same channel takes the shorter path that skips calibration. A host sees the state code, a busy flag, a one-cycle ready pulse on completion, and a sticky error flag for commands that arrived while a transition was still running.

Top module: `radio_seq_ctrl`

## Requirements
- R1: After rst_n the state is IDLE (code 0), busy_o, ready_o and err_o are low, and no channel counts as calibrated.
- R2: Command bytes are 0xA1 idle, 0xA2 PHY ready, 0xA3 receive, 0xA4 transmit, 0xA5 CCA, 0xA6 measure, 0xA7 sleep and 0xA8 reset. State codes are IDLE 0, PHY 1, RX 2, TX 3, CCA 4, MEAS 5, SLEEP 6. A recognised command that has no transition from the current state is ignored. Examples are receive from IDLE and PHY ready from SLEEP.
- R3: busy_o rises in the cycle after a command is accepted and stays high until the target state is reached. In the cycle where state_o first shows the target, busy_o is low and ready_o is high for exactly one cycle.
- R4: One tick occurs every TICK_DIV clocks. A transition of D ticks keeps busy_o high for between (D-1)*TICK_DIV+2 and D*TICK_DIV+1 cycles, and for 1 cycle when D is 0.
- R5: IDLE to PHY takes 284 ticks with mode_fsk_i low and 360 ticks with it high. PHY to IDLE takes 27 ticks.
- R6: Receive or transmit entry from PHY, RX or TX takes 384 ticks plus mac_ext_i when calibration is needed. Otherwise it takes 280 ticks plus mac_ext_i. Calibration is needed when no channel is calibrated or chan_i differs from the last calibrated channel. Reaching IDLE or SLEEP, or a reset command, forgets the calibrated channel.
- R7: Fixed intervals in ticks: RX or TX to PHY 46, PHY to CCA 384, CCA to PHY 29, RX to CCA 36, CCA to RX 410, RX to IDLE 11, TX to IDLE 61, CCA to IDLE 29, IDLE to MEAS 38, MEAS to IDLE 12.
- R8: A recognised non-reset command that arrives while busy_o is high is rejected and leaves the running transition unchanged. It sets err_o, which stays high until a reset command or rst_n.
- R9: A byte outside 0xA1..0xA8 is ignored. A receive command in RX, or a transmit command in TX, on the calibrated channel is also ignored.
- R10: A reset command acts in the next cycle from any state, busy or not. It gives IDLE, busy_o low, err_o low, and no ready pulse.
- R11: SLEEP is entered from IDLE only and left to IDLE only, each with a zero-tick interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command byte present this cycle |
| cmd_byte_i | input | 8 | Command code |
| mode_fsk_i | input | 1 | 1 selects the FSK mode timing, 0 the 802.15.4 timing |
| chan_i | input | CH_W | Channel number requested for receive/transmit entry |
| mac_ext_i | input | EXT_W | MAC delay extension in half-microsecond ticks |
| state_o | output | 3 | Current state code |
| busy_o | output | 1 | Transition in progress |
| ready_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky rejected-command flag |

## Verification
The assertions assume that rst_n is held for at least one clock edge and that the tick stays regular. They also assume that the cycle of a command is judged only on the busy_o value of that same cycle. The stimulus sends each command as a single-cycle pulse on a falling edge. It changes chan_i, mode_fsk_i and mac_ext_i only while no transition is running, so every interval is decided by stable settings. Rejected commands and mid-transition resets are the only inputs placed inside a busy window.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PHY   = 3'd1,
      ST_RX    = 3'd2,
      ST_TX    = 3'd3,
      ST_CCA   = 3'd4,
      ST_MEAS  = 3'd5,
      ST_SLEEP = 3'd6
   } rsq_state_e;

   localparam logic [7:0] CMD_IDLE  = 8'hA1;
   localparam logic [7:0] CMD_PHY   = 8'hA2;
   localparam logic [7:0] CMD_RX    = 8'hA3;
   localparam logic [7:0] CMD_TX    = 8'hA4;
   localparam logic [7:0] CMD_CCA   = 8'hA5;
   localparam logic [7:0] CMD_MEAS  = 8'hA6;
   localparam logic [7:0] CMD_SLEEP = 8'hA7;
   localparam logic [7:0] CMD_RESET = 8'hA8;

   // settling intervals, half-microsecond ticks
   localparam int unsigned T_IDLE_PHY_STD = 284;
   localparam int unsigned T_IDLE_PHY_FSK = 360;
   localparam int unsigned T_PHY_IDLE     = 27;
   localparam int unsigned T_TUNE_CAL     = 384;
   localparam int unsigned T_TUNE_SKIP    = 280;
   localparam int unsigned T_TRX_PHY      = 46;
   localparam int unsigned T_PHY_CCA      = 384;
   localparam int unsigned T_CCA_PHY      = 29;
   localparam int unsigned T_RX_CCA       = 36;
   localparam int unsigned T_CCA_RX       = 410;
   localparam int unsigned T_RX_IDLE      = 11;
   localparam int unsigned T_TX_IDLE      = 61;
   localparam int unsigned T_CCA_IDLE     = 29;
   localparam int unsigned T_IDLE_MEAS    = 38;
   localparam int unsigned T_MEAS_IDLE    = 12;
   localparam int unsigned T_SLEEP_EDGE   = 0;

   localparam int unsigned T_LONGEST_FIXED = 410;

endpackage

// File: rtl/rsq_tick_gen.sv
`timescale 1ns/1ps
module rsq_tick_gen #(
   parameter int unsigned TICK_DIV = 25
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("rsq_tick_gen: TICK_DIV must be at least 1");
      end

      if (TICK_DIV == 1) begin : g_every_clock
         assign tick_o = 1'b1;
      end else begin : g_divided
         localparam int unsigned CW = $clog2(TICK_DIV);
         localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
         logic [CW-1:0] div_q;

         assign tick_o = (div_q == LAST);

         always_ff @(posedge clk) begin
            if (!rst_n)      div_q <= '0;
            else if (tick_o) div_q <= '0;
            else             div_q <= div_q + 1'b1;
         end

         // R4: ticks never come on back-to-back clocks when dividing
         a_r4_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
      end
   endgenerate
endmodule

// File: rtl/rsq_cmd_decode.sv
`timescale 1ns/1ps
module rsq_cmd_decode
   import rsq_pkg::*;
(
   input  logic [7:0]  byte_i,
   output logic        known_o,
   output logic        is_reset_o,
   output rsq_state_e  target_o
);
   always_comb begin
      known_o    = 1'b1;
      is_reset_o = 1'b0;
      target_o   = ST_IDLE;
      case (byte_i)
         CMD_IDLE:  target_o = ST_IDLE;
         CMD_PHY:   target_o = ST_PHY;
         CMD_RX:    target_o = ST_RX;
         CMD_TX:    target_o = ST_TX;
         CMD_CCA:   target_o = ST_CCA;
         CMD_MEAS:  target_o = ST_MEAS;
         CMD_SLEEP: target_o = ST_SLEEP;
         CMD_RESET: is_reset_o = 1'b1;
         default:   known_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/rsq_delay_lut.sv
`timescale 1ns/1ps
module rsq_delay_lut
   import rsq_pkg::*;
#(
   parameter int unsigned EXT_W = 12,
   parameter int unsigned DLY_W = EXT_W + 1
) (
   input  rsq_state_e         cur_i,
   input  rsq_state_e         tgt_i,
   input  logic               mode_fsk_i,
   input  logic               need_cal_i,
   input  logic [EXT_W-1:0]   ext_i,
   output logic               legal_o,
   output logic               tune_o,
   output logic [DLY_W-1:0]   delay_o
);
   logic [DLY_W-1:0] base;
   logic             add_ext;
   logic [DLY_W-1:0] tune_base;

   assign tune_base = need_cal_i ? DLY_W'(T_TUNE_CAL) : DLY_W'(T_TUNE_SKIP);

   always_comb begin
      legal_o = 1'b0;
      tune_o  = 1'b0;
      add_ext = 1'b0;
      base    = '0;
      case (cur_i)
         ST_IDLE: begin
            case (tgt_i)
               ST_PHY: begin
                  legal_o = 1'b1;
                  base = mode_fsk_i ? DLY_W'(T_IDLE_PHY_FSK) : DLY_W'(T_IDLE_PHY_STD);
               end
               ST_MEAS:  begin legal_o = 1'b1; base = DLY_W'(T_IDLE_MEAS);  end
               ST_SLEEP: begin legal_o = 1'b1; base = DLY_W'(T_SLEEP_EDGE); end
               default: ;
            endcase
         end
         ST_PHY: begin
            case (tgt_i)
               ST_IDLE: begin legal_o = 1'b1; base = DLY_W'(T_PHY_IDLE); end
               ST_CCA:  begin legal_o = 1'b1; base = DLY_W'(T_PHY_CCA);  end
               ST_RX, ST_TX: begin
                  legal_o = 1'b1; tune_o = 1'b1; add_ext = 1'b1; base = tune_base;
               end
               default: ;
            endcase
         end
         ST_RX: begin
            case (tgt_i)
               ST_IDLE: begin legal_o = 1'b1; base = DLY_W'(T_RX_IDLE); end
               ST_PHY:  begin legal_o = 1'b1; base = DLY_W'(T_TRX_PHY); end
               ST_CCA:  begin legal_o = 1'b1; base = DLY_W'(T_RX_CCA);  end
               ST_TX: begin
                  legal_o = 1'b1; tune_o = 1'b1; add_ext = 1'b1; base = tune_base;
               end
               ST_RX: begin
                  legal_o = need_cal_i; tune_o = need_cal_i;
                  add_ext = 1'b1; base = tune_base;
               end
               default: ;
            endcase
         end
         ST_TX: begin
            case (tgt_i)
               ST_IDLE: begin legal_o = 1'b1; base = DLY_W'(T_TX_IDLE); end
               ST_PHY:  begin legal_o = 1'b1; base = DLY_W'(T_TRX_PHY); end
               ST_RX: begin
                  legal_o = 1'b1; tune_o = 1'b1; add_ext = 1'b1; base = tune_base;
               end
               ST_TX: begin
                  legal_o = need_cal_i; tune_o = need_cal_i;
                  add_ext = 1'b1; base = tune_base;
               end
               default: ;
            endcase
         end
         ST_CCA: begin
            case (tgt_i)
               ST_IDLE: begin legal_o = 1'b1; base = DLY_W'(T_CCA_IDLE); end
               ST_PHY:  begin legal_o = 1'b1; base = DLY_W'(T_CCA_PHY);  end
               ST_RX:   begin legal_o = 1'b1; base = DLY_W'(T_CCA_RX);   end
               default: ;
            endcase
         end
         ST_MEAS: begin
            if (tgt_i == ST_IDLE) begin legal_o = 1'b1; base = DLY_W'(T_MEAS_IDLE); end
         end
         ST_SLEEP: begin
            if (tgt_i == ST_IDLE) begin legal_o = 1'b1; base = DLY_W'(T_SLEEP_EDGE); end
         end
         default: ;
      endcase
   end

   assign delay_o = base + (add_ext ? {{(DLY_W-EXT_W){1'b0}}, ext_i} : '0);

   // R11: sleep edges are always zero-length
   always_comb begin
      if (legal_o && (tgt_i == ST_SLEEP || cur_i == ST_SLEEP))
         a_r11_sleep_zero: assert (delay_o == '0);
   end
endmodule

// File: rtl/rsq_timer.sv
`timescale 1ns/1ps
module rsq_timer #(
   parameter int unsigned DLY_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DLY_W-1:0] load_val_i,
   input  logic             tick_i,
   input  logic             abort_i,
   output logic             busy_o,
   output logic             expire_o
);
   logic [DLY_W-1:0] left_q;
   logic             busy_q;

   assign busy_o   = busy_q;
   assign expire_o = busy_q && (left_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (abort_i) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (load_i) begin
         busy_q <= 1'b1;
         left_q <= load_val_i;
      end else if (busy_q) begin
         if (left_q == '0)  busy_q <= 1'b0;
         else if (tick_i)   left_q <= left_q - 1'b1;
      end
   end

   // R8: a new interval is only started while none is running
   a_r8_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !busy_q);

   // R4: the remaining count only moves on a tick
   a_r4_count_waits_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && left_q != '0 && !tick_i && !abort_i) |=> (left_q == $past(left_q)));
endmodule

// File: rtl/radio_seq_ctrl.sv
`timescale 1ns/1ps
module radio_seq_ctrl
   import rsq_pkg::*;
#(
   parameter int unsigned TICK_DIV = 25,
   parameter int unsigned CH_W     = 7,
   parameter int unsigned EXT_W    = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid_i,
   input  logic [7:0]       cmd_byte_i,
   input  logic             mode_fsk_i,
   input  logic [CH_W-1:0]  chan_i,
   input  logic [EXT_W-1:0] mac_ext_i,
   output logic [2:0]       state_o,
   output logic             busy_o,
   output logic             ready_o,
   output logic             err_o
);
   localparam int unsigned DLY_W = EXT_W + 1;

   generate
      if (CH_W < 1) begin : g_bad_ch
         $error("radio_seq_ctrl: CH_W must be at least 1");
      end
      if ((1 << EXT_W) <= T_LONGEST_FIXED) begin : g_bad_ext
         $error("radio_seq_ctrl: EXT_W too narrow for the fixed intervals");
      end
   endgenerate

   rsq_state_e       state_q, target_q, dec_tgt;
   logic             ready_q, err_q;
   logic             cal_valid_q, pend_tune_q;
   logic [CH_W-1:0]  cal_chan_q, pend_chan_q;
   logic             dec_known, dec_reset;
   logic             tick, need_cal, legal, tune;
   logic [DLY_W-1:0] delay;
   logic             busy, expire, rst_cmd, accept;

   rsq_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   rsq_cmd_decode dec_i (
      .byte_i     (cmd_byte_i),
      .known_o    (dec_known),
      .is_reset_o (dec_reset),
      .target_o   (dec_tgt)
   );

   assign need_cal = !cal_valid_q || (chan_i != cal_chan_q);

   rsq_delay_lut #(.EXT_W(EXT_W), .DLY_W(DLY_W)) lut_i (
      .cur_i      (state_q),
      .tgt_i      (dec_tgt),
      .mode_fsk_i (mode_fsk_i),
      .need_cal_i (need_cal),
      .ext_i      (mac_ext_i),
      .legal_o    (legal),
      .tune_o     (tune),
      .delay_o    (delay)
   );

   assign rst_cmd = cmd_valid_i && dec_reset;
   assign accept  = cmd_valid_i && dec_known && !dec_reset && !busy && legal;

   rsq_timer #(.DLY_W(DLY_W)) tmr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .load_val_i (delay),
      .tick_i     (tick),
      .abort_i    (rst_cmd),
      .busy_o     (busy),
      .expire_o   (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         target_q    <= ST_IDLE;
         ready_q     <= 1'b0;
         err_q       <= 1'b0;
         cal_valid_q <= 1'b0;
         cal_chan_q  <= '0;
         pend_chan_q <= '0;
         pend_tune_q <= 1'b0;
      end else begin
         ready_q <= 1'b0;
         if (rst_cmd) begin
            state_q     <= ST_IDLE;
            err_q       <= 1'b0;
            cal_valid_q <= 1'b0;
         end else begin
            if (accept) begin
               target_q    <= dec_tgt;
               pend_chan_q <= chan_i;
               pend_tune_q <= tune;
            end
            if (busy && cmd_valid_i && dec_known) err_q <= 1'b1;
            if (expire) begin
               state_q <= target_q;
               ready_q <= 1'b1;
               if (pend_tune_q) begin
                  cal_valid_q <= 1'b1;
                  cal_chan_q  <= pend_chan_q;
               end
               if (target_q == ST_IDLE || target_q == ST_SLEEP) cal_valid_q <= 1'b0;
            end
         end
      end
   end

   assign state_o = state_q;
   assign busy_o  = busy;
   assign ready_o = ready_q;
   assign err_o   = err_q;

   // R3: completion is a single pulse
   a_r3_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |=> !ready_q);

   // R3: the pulse never overlaps a running transition
   a_r3_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |-> !busy);

   // R3: the state register holds while the interval runs
   a_r3_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !expire && !rst_cmd) |=> (state_q == $past(state_q)));

   // R8: the error flag only falls through a reset command
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !rst_cmd) |=> err_q);

   // R10: reset command takes effect on the next edge
   a_r10_reset_now: assert property (@(posedge clk) disable iff (!rst_n)
      rst_cmd |=> (state_q == ST_IDLE && !busy && !err_q && !ready_q));

   // R11: sleep is left only towards idle
   a_r11_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP) |=> (state_q == ST_SLEEP || state_q == ST_IDLE));

   // R2: the state code stays inside the defined set
   a_r2_state_code: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 3'd7);
endmodule

// File: tb/radio_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module radio_seq_ctrl_tb_top;
   localparam int BDIV  = 2;
   localparam int CH_W  = 7;
   localparam int EXT_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic [7:0]       cmd_byte = 8'h00;
   logic             mode_fsk = 1'b0;
   logic [CH_W-1:0]  chan = 7'd5;
   logic [EXT_W-1:0] mac_ext = '0;
   logic [2:0]       state_o;
   logic             busy_o, ready_o, err_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit cmp_en  = 1'b0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   radio_seq_ctrl #(.TICK_DIV(BDIV), .CH_W(CH_W), .EXT_W(EXT_W)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid_i (cmd_valid),
      .cmd_byte_i  (cmd_byte),
      .mode_fsk_i  (mode_fsk),
      .chan_i      (chan),
      .mac_ext_i   (mac_ext),
      .state_o     (state_o),
      .busy_o      (busy_o),
      .ready_o     (ready_o),
      .err_o       (err_o)
   );

   // ---------------- behavioural reference model ----------------
   int m_state, m_target, m_rem, m_pre, m_calch, m_pendch;
   bit m_busy, m_ready, m_err, m_calv, m_pendcal;

   function automatic void m_lookup(input int from, input int to, input bit fsk,
                                    input bit nc, input int ext,
                                    output bit ok, output int d, output bit tn);
      int tune_d;
      tune_d = (nc ? 384 : 280) + ext;
      ok = 1'b1; tn = 1'b0; d = 0;
      if      (from == 0 && to == 1) d = fsk ? 360 : 284;
      else if (from == 0 && to == 5) d = 38;
      else if (from == 0 && to == 6) d = 0;
      else if (from == 1 && to == 0) d = 27;
      else if (from == 1 && to == 4) d = 384;
      else if ((from == 1 || from == 2 || from == 3) && (to == 2 || to == 3)) begin
         if (from == to && !nc) ok = 1'b0;
         else begin d = tune_d; tn = 1'b1; end
      end
      else if (from == 2 && to == 0) d = 11;
      else if (from == 2 && to == 1) d = 46;
      else if (from == 2 && to == 4) d = 36;
      else if (from == 3 && to == 0) d = 61;
      else if (from == 3 && to == 1) d = 46;
      else if (from == 4 && to == 0) d = 29;
      else if (from == 4 && to == 1) d = 29;
      else if (from == 4 && to == 2) d = 410;
      else if (from == 5 && to == 0) d = 12;
      else if (from == 6 && to == 0) d = 0;
      else ok = 1'b0;
   endfunction

   always @(posedge clk) begin
      bit tk, ok, tn, nc;
      int d, tgt;
      if (!rst_n) begin
         m_state = 0; m_target = 0; m_rem = 0; m_pre = 0; m_busy = 0;
         m_ready = 0; m_err = 0; m_calv = 0; m_calch = 0; m_pendch = 0; m_pendcal = 0;
      end else begin
         tk = (m_pre == BDIV - 1);
         m_pre = tk ? 0 : m_pre + 1;
         m_ready = 0;
         if (cmd_valid && cmd_byte == 8'hA8) begin
            m_state = 0; m_busy = 0; m_err = 0; m_calv = 0;
         end else if (m_busy) begin
            if (cmd_valid && cmd_byte >= 8'hA1 && cmd_byte <= 8'hA7) m_err = 1;
            if (m_rem == 0) begin
               m_state = m_target; m_busy = 0; m_ready = 1;
               if (m_pendcal) begin m_calv = 1; m_calch = m_pendch; end
               if (m_target == 0 || m_target == 6) m_calv = 0;
            end else if (tk) m_rem--;
         end else if (cmd_valid && cmd_byte >= 8'hA1 && cmd_byte <= 8'hA7) begin
            tgt = (cmd_byte == 8'hA1) ? 0 : int'(cmd_byte) - 'hA1;
            nc  = !m_calv || (int'(chan) != m_calch);
            m_lookup(m_state, tgt, mode_fsk, nc, int'(mac_ext), ok, d, tn);
            if (ok) begin
               m_busy = 1; m_rem = d; m_target = tgt;
               m_pendch = int'(chan); m_pendcal = tn;
            end
         end
      end
   end

   // R3: per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_en && !done) begin
         n_tests++;
         if (int'(state_o) != m_state || busy_o != m_busy || ready_o != m_ready || err_o != m_err) begin
            n_fail++;
            $display("FAIL R3 model compare: actual st=%0d busy=%0d rdy=%0d err=%0d expected st=%0d busy=%0d rdy=%0d err=%0d",
                     state_o, busy_o, ready_o, err_o, m_state, m_busy, m_ready, m_err);
         end
      end
   end

   // ---------------- directed checks ----------------
   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] c);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_byte = c;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_byte = 8'h00;
   endtask

   task automatic do_cmd(input logic [7:0] c, input int d, input int st, input string tag);
      int cnt, lo, hi;
      send(c);
      cnt = 0;
      while (busy_o && cnt < 20000) begin
         cnt++;
         @(negedge clk);
      end
      lo = (d == 0) ? 1 : (d - 1) * BDIV + 2;
      hi = (d == 0) ? 1 : d * BDIV + 1;
      chk(cnt >= lo && cnt <= hi, tag, "busy cycles (lower bound shown)", cnt, lo);
      chk(ready_o == 1'b1, tag, "ready pulse", int'(ready_o), 1);
      chk(int'(state_o) == st, tag, "state reached", int'(state_o), st);
   endtask

   task automatic expect_ignored(input logic [7:0] c, input int st, input string tag);
      send(c);
      for (int i = 0; i < 4; i++) begin
         chk(busy_o == 1'b0 && int'(state_o) == st, tag, "ignored command state", int'(state_o), st);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(int'(state_o) == 0, "R1", "state", int'(state_o), 0);
      chk(busy_o == 1'b0, "R1", "busy", int'(busy_o), 0);
      chk(ready_o == 1'b0, "R1", "ready", int'(ready_o), 0);
      chk(err_o == 1'b0, "R1", "err", int'(err_o), 0);
      rst_n = 1'b1;
      cmp_en = 1'b1;

      do_cmd(8'hA2, 284, 1, "R5");
      do_cmd(8'hA3, 384, 2, "R6");   // first entry needs calibration
      do_cmd(8'hA4, 280, 3, "R6");   // same channel skips it
      expect_ignored(8'hA4, 3, "R9");
      @(negedge clk) chan = 7'd9;
      do_cmd(8'hA4, 384, 3, "R6");   // channel change while in TX
      do_cmd(8'hA3, 280, 2, "R6");
      do_cmd(8'hA5, 36, 4, "R7");
      do_cmd(8'hA3, 410, 2, "R7");
      do_cmd(8'hA1, 11, 0, "R7");
      expect_ignored(8'h00, 0, "R9");
      expect_ignored(8'h3C, 0, "R9");
      expect_ignored(8'hA3, 0, "R2");  // receive straight from idle
      do_cmd(8'hA6, 38, 5, "R7");
      do_cmd(8'hA1, 12, 0, "R7");
      do_cmd(8'hA7, 0, 6, "R11");
      expect_ignored(8'hA2, 6, "R11");
      do_cmd(8'hA1, 0, 0, "R11");

      @(negedge clk) mode_fsk = 1'b1;
      do_cmd(8'hA2, 360, 1, "R5");
      do_cmd(8'hA5, 384, 4, "R7");
      do_cmd(8'hA2, 29, 1, "R7");
      @(negedge clk) mac_ext = 12'd944;
      do_cmd(8'hA4, 1328, 3, "R6");
      do_cmd(8'hA3, 1224, 2, "R6");

      // R8: command during a running transition
      send(8'hA2);
      cmd_valid = 1'b1; cmd_byte = 8'hA5;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_byte = 8'h00;
      while (busy_o) @(negedge clk);
      chk(int'(state_o) == 1, "R8", "state after rejected command", int'(state_o), 1);
      chk(err_o == 1'b1, "R8", "error flag", int'(err_o), 1);
      do_cmd(8'hA1, 27, 0, "R5");
      chk(err_o == 1'b1, "R8", "error flag sticky", int'(err_o), 1);

      // R10: reset command in the middle of a transition
      @(negedge clk) mac_ext = '0;
      send(8'hA2);
      repeat (10) @(negedge clk);
      send(8'hA8);
      chk(int'(state_o) == 0, "R10", "state", int'(state_o), 0);
      chk(busy_o == 1'b0, "R10", "busy", int'(busy_o), 0);
      chk(err_o == 1'b0, "R10", "err cleared", int'(err_o), 0);
      chk(ready_o == 1'b0, "R10", "no ready", int'(ready_o), 0);

      do_cmd(8'hA2, 360, 1, "R5");
      do_cmd(8'hA4, 384, 3, "R6");
      do_cmd(8'hA1, 61, 0, "R7");
      do_cmd(8'hA2, 360, 1, "R5");
      do_cmd(8'hA5, 384, 4, "R7");
      do_cmd(8'hA1, 29, 0, "R7");
      do_cmd(8'hA2, 360, 1, "R5");
      do_cmd(8'hA3, 384, 2, "R6");  // calibration forgotten after idle
      do_cmd(8'hA2, 46, 1, "R7");
      do_cmd(8'hA3, 280, 2, "R6");
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule